// File: doc/BRIEF.md
# Serial Chien Root Search over GF(2^8)

This block finds the roots of an error-locator polynomial for a binary BCH decoder whose codewords are 255 bits long. After a one-cycle load strobe delivers the locator coefficients, the block tests one nonzero field element per clock. It reports, for every codeword bit position in turn, whether that position holds an error. The position stream runs from the highest-degree bit (254) down to bit 0, which is the order in which a codeword buffer is read. A downstream stage can therefore XOR the error flag into the buffered bit in the same cycle. When the sweep ends, the block pulses a done flag, reports how many roots it found, and raises an uncorrectable flag if that count does not equal the degree of the locator.

Each locator term has its own register that starts at `coef_j * alpha^j`. Every cycle the register is multiplied by the constant `alpha^j`, so the evaluation needs only constant multipliers, which are plain XOR networks. The XOR of all term registers is zero exactly when the current element is a root. At sweep step `s` the element under test is `alpha^(s+1)`, which is the inverse of `alpha^(254-s)`. Step `s` therefore reports bit position `254-s`.

The controller has three states. `ST_IDLE` waits for a load. The transition *start* (load in `ST_IDLE` or `ST_FINISH`) enters `ST_SWEEP`. `ST_SWEEP` steps through all 255 elements. The transition *last* (step 254 completed) enters `ST_FINISH`. `ST_FINISH` lasts one cycle and then takes the transition *rest* back to `ST_IDLE`, unless a new load starts another sweep.

Top module: `chien_serial_finder`

## Requirements
- R1: After reset, `done`, `err_valid`, `err_bit` and `uncorrectable` are 0 and `root_count` is 0.
- R2: Field arithmetic is GF(2^8) with the primitive polynomial x^8+x^4+x^3+x^2+1 (0x11D). `alpha` is the element 0x02. Coefficient j of the locator occupies bits [8j+7:8j] of `loc_coef`, with j = 0 the constant term.
- R3: A load sampled on a clock edge while not sweeping makes `err_valid` high for exactly the 255 following cycles. During those cycles `err_pos` counts 254, 253, … down to 0, one step per cycle.
- R4: `err_bit` is high in the cycle where `err_pos` = p exactly when the locator evaluates to zero at alpha^(255-p mod 255). For a locator built as the product of (1 + alpha^e x) over distinct positions e, this flags exactly those positions.
- R5: `done` is high for exactly one cycle, in the cycle right after the cycle with `err_pos` = 0.
- R6: In the `done` cycle, `root_count` equals the number of flagged positions of the sweep. It keeps that value until the next accepted load.
- R7: `uncorrectable` is high whenever the block is not sweeping and `root_count` differs from the locator degree. The degree is the highest index j with a nonzero coefficient, or 0 if none is nonzero. It is low during a sweep.
- R8: A load strobe raised during a sweep is ignored. The sweep, its flags and its count continue unchanged.
- R9: A locator equal to the constant 1 flags no position, gives `root_count` = 0 and leaves `uncorrectable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Start strobe; `loc_coef` is sampled with it |
| loc_coef | input | 72 | Locator coefficients, 8 bits each, j = 0..8 |
| err_valid | output | 1 | A position is being reported this cycle |
| err_bit | output | 1 | The reported position is in error |
| err_pos | output | 8 | Bit position being reported, 254 down to 0 |
| done | output | 1 | One-cycle pulse after the last position |
| root_count | output | 8 | Roots found in the current or last sweep |
| uncorrectable | output | 1 | Root count differs from the locator degree |

## Verification
The hardest conditions to reach from the ports are the ones where the root count and the degree disagree. A valid error pattern never produces them. The stimulus creates them on purpose. One case uses a squared linear factor, whose single repeated root counts once against a degree of two. Another uses an all-zero locator, which makes every element a root and drives the count to its 255 ceiling. Roots at the first step and the last step of the sweep are placed with single-error locators for positions 254 and 0. A load strobe is also raised in the middle of a sweep to show that the sweep results do not change.

// File: rtl/chien_pkg.sv
package chien_pkg;

    localparam int GF_M    = 8;
    localparam int GF_N    = (1 << GF_M) - 1;
    localparam int GF_POLY = 'h11D;

    typedef logic [GF_M-1:0] gf_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_FINISH = 2'd2
    } finder_state_e;

    // multiply by alpha once
    function automatic gf_t gf_xtime(input gf_t a);
        gf_t r;
        r = {a[GF_M-2:0], 1'b0};
        if (a[GF_M-1]) r = r ^ gf_t'(GF_POLY);
        return r;
    endfunction

    // multiply by the constant alpha^k, k small and fixed per instance
    function automatic gf_t gf_mul_apow(input gf_t a, input int k);
        gf_t r;
        r = a;
        for (int n = 0; n < 64; n++) begin
            if (n < k) r = gf_xtime(r);
        end
        return r;
    endfunction

endpackage

// File: rtl/chien_term.sv
module chien_term
    import chien_pkg::*;
#(
    parameter int J = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic step_en,
    input  gf_t  coef_in,
    output gf_t  term
);

    gf_t term_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_q <= '0;
        end else if (load_en) begin
            term_q <= gf_mul_apow(coef_in, J);
        end else if (step_en) begin
            term_q <= gf_mul_apow(term_q, J);
        end
    end

    assign term = term_q;

endmodule

// File: rtl/chien_sum.sv
module chien_sum
    import chien_pkg::*;
#(
    parameter int T = 8
) (
    input  logic [T:0][GF_M-1:0] terms,
    output logic                 is_root
);

    gf_t acc;

    always_comb begin
        acc = '0;
        for (int j = 0; j <= T; j++) begin
            acc = acc ^ terms[j];
        end
        is_root = (acc == '0);
    end

endmodule

// File: rtl/chien_ctrl.sv
module chien_ctrl
    import chien_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic is_root,
    output logic load_en,
    output logic step_en,
    output logic err_valid,
    output logic err_bit,
    output gf_t  err_pos,
    output logic done,
    output logic idle_like,
    output gf_t  root_count
);

    localparam gf_t LAST_STEP = gf_t'(GF_N - 1);
    localparam gf_t ONE       = gf_t'(1);

    finder_state_e state_q, state_d;
    gf_t           step_q;
    gf_t           count_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, last, rest
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = ST_SWEEP;
            ST_SWEEP:  if (step_q == LAST_STEP) state_d = ST_FINISH;
            ST_FINISH: state_d = load ? ST_SWEEP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_en   = 1'b0;
        step_en   = 1'b0;
        err_valid = 1'b0;
        done      = 1'b0;
        idle_like = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                load_en = load;
            end
            ST_SWEEP: begin
                step_en   = 1'b1;
                err_valid = 1'b1;
                idle_like = 1'b0;
            end
            ST_FINISH: begin
                load_en = load;
                done    = 1'b1;
            end
            default: ;
        endcase
        err_bit = err_valid & is_root;
        err_pos = LAST_STEP - step_q;
    end

    // step counter and root counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q  <= '0;
            count_q <= '0;
        end else if (load_en) begin
            step_q  <= '0;
            count_q <= '0;
        end else if (step_en) begin
            step_q <= step_q + ONE;
            if (is_root) count_q <= count_q + ONE;
        end
    end

    assign root_count = count_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(err_valid) && $past(err_pos) == '0)); // R5

    AST_FIRST_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_valid) |-> err_pos == LAST_STEP); // R3

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && $past(err_valid)) |-> err_pos == $past(err_pos) - ONE); // R3

    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && load && err_pos != '0) |=>
            (err_valid && err_pos == $past(err_pos) - ONE)); // R8

endmodule

// File: rtl/chien_serial_finder.sv
module chien_serial_finder
    import chien_pkg::*;
#(
    parameter int T = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [(T+1)*GF_M-1:0]   loc_coef,
    output logic                    err_valid,
    output logic                    err_bit,
    output logic [GF_M-1:0]         err_pos,
    output logic                    done,
    output logic [GF_M-1:0]         root_count,
    output logic                    uncorrectable
);

    logic                 load_en;
    logic                 step_en;
    logic                 is_root;
    logic                 idle_like;
    logic [T:0][GF_M-1:0] terms;
    gf_t                  deg_d, deg_q;

    for (genvar j = 0; j <= T; j++) begin : g_term
        chien_term #(.J(j)) u_term (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_en (load_en),
            .step_en (step_en),
            .coef_in (loc_coef[j*GF_M +: GF_M]),
            .term    (terms[j])
        );
    end

    chien_sum #(.T(T)) u_sum (
        .terms   (terms),
        .is_root (is_root)
    );

    chien_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .is_root    (is_root),
        .load_en    (load_en),
        .step_en    (step_en),
        .err_valid  (err_valid),
        .err_bit    (err_bit),
        .err_pos    (err_pos),
        .done       (done),
        .idle_like  (idle_like),
        .root_count (root_count)
    );

    // locator degree: highest nonzero coefficient index
    always_comb begin
        deg_d = '0;
        for (int j = 1; j <= T; j++) begin
            if (loc_coef[j*GF_M +: GF_M] != '0) deg_d = gf_t'(j);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       deg_q <= '0;
        else if (load_en) deg_q <= deg_d;
    end

    assign uncorrectable = idle_like && (root_count != deg_q);

    AST_FLAG_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        err_bit |-> err_valid); // R4

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_valid && $past(!err_valid)) |-> $stable(root_count)); // R6

    AST_UNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !uncorrectable); // R7

endmodule

// File: tb/sim_chien_serial_finder.sv
module sim_chien_serial_finder;

    localparam int BT = 8;
    localparam int W  = (BT+1)*8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] loc_coef = '0;
    logic         err_valid, err_bit, done, uncorrectable;
    logic [7:0]   err_pos, root_count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    chien_serial_finder #(.T(BT)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .loc_coef(loc_coef),
        .err_valid(err_valid), .err_bit(err_bit), .err_pos(err_pos),
        .done(done), .root_count(root_count), .uncorrectable(uncorrectable)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] apow(input int e);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < (e % 255); i++) r = gmul(r, 8'h02);
        return r;
    endfunction

    function automatic logic [7:0] evalp(input logic [W-1:0] s, input logic [7:0] x);
        logic [7:0] acc = 0;
        logic [7:0] xp = 8'h01;
        for (int j = 0; j <= BT; j++) begin
            acc ^= gmul(s[j*8 +: 8], xp);
            xp = gmul(xp, x);
        end
        return acc;
    endfunction

    function automatic int degof(input logic [W-1:0] s);
        int d = 0;
        for (int j = 1; j <= BT; j++) if (s[j*8 +: 8] != 0) d = j;
        return d;
    endfunction

    // product of (1 + alpha^e x) over the given positions
    function automatic logic [W-1:0] from_errs(input int e[$]);
        logic [W-1:0] s = '0;
        s[7:0] = 8'h01;
        foreach (e[k]) begin
            logic [W-1:0] n = s;
            for (int j = 1; j <= BT; j++)
                n[j*8 +: 8] = s[j*8 +: 8] ^ gmul(apow(e[k]), s[(j-1)*8 +: 8]);
            s = n;
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(done == 0 && err_valid == 0 && err_bit == 0, "R1 flags", {done, err_valid, err_bit}, 0);
        chk(root_count == 0, "R1 root_count", root_count, 0);
        chk(uncorrectable == 0, "R1 uncorrectable", uncorrectable, 0);
    endtask

    // one sweep; inject >= 0 raises a stray load at that step (R8)
    task automatic run_case(input string name, input logic [W-1:0] s, input int inject);
        bit exp_flag[255];
        int exp_cnt = 0;
        int win_bad = 0;
        int flag_bad = 0;
        int exp_deg = degof(s);
        bit exp_unc;
        logic [7:0] held;
        for (int p = 0; p < 255; p++) begin
            exp_flag[p] = (evalp(s, apow((255 - p) % 255)) == 0);
            if (exp_flag[p]) exp_cnt++;
        end
        exp_unc = (exp_cnt != exp_deg);
        @(negedge clk);
        load = 1'b1;
        loc_coef = s;
        @(negedge clk);
        load = 1'b0;
        loc_coef = '0;
        for (int k = 0; k < 255; k++) begin
            if (!err_valid || err_pos != 8'(254 - k) || done) begin
                win_bad++;
                $display("FAIL R3 %s step %0d: actual pos %0d valid %0d expected pos %0d valid 1",
                         name, k, err_pos, err_valid, 254 - k);
            end
            if (err_bit != exp_flag[254 - k]) begin
                flag_bad++;
                $display("FAIL R4 %s pos %0d: actual %0d expected %0d",
                         name, 254 - k, err_bit, exp_flag[254 - k]);
            end
            if (k == inject) begin
                load = 1'b1;
                loc_coef = '0;
            end
            @(negedge clk);
            load = 1'b0;
        end
        chk(win_bad == 0, {"R3 window ", name}, win_bad, 0);
        chk(flag_bad == 0, {"R4 flags ", name}, flag_bad, 0);
        chk(done == 1 && err_valid == 0, {"R5 done ", name}, done, 1);
        chk(root_count == 8'(exp_cnt), {"R6 count ", name}, root_count, exp_cnt);
        chk(uncorrectable == exp_unc, {"R7 uncorrectable ", name}, uncorrectable, exp_unc);
        held = root_count;
        @(negedge clk);
        chk(done == 0 && err_valid == 0, {"R5 done width ", name}, done, 0);
        chk(root_count == held, {"R6 hold ", name}, root_count, held);
    endtask

    initial begin
        int e8[$] = '{0, 3, 77, 128, 200, 201, 253, 254};
        logic [W-1:0] sq;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();

        // R9: no errors
        run_case("R9 constant one", from_errs('{}), -1);
        // R4 boundaries: first and last step
        run_case("R4 pos254", from_errs('{254}), -1);
        run_case("R4 pos0", from_errs('{0}), -1);
        // R2/R4: full-degree pattern
        run_case("R2 eight errors", from_errs(e8), -1);
        // R7: repeated root, count 1 against degree 2
        sq = '0;
        sq[7:0]   = 8'h01;
        sq[23:16] = apow(10);
        run_case("R7 repeated root", sq, -1);
        // R7: all zero locator, every element a root
        run_case("R7 zero locator", '0, -1);
        // R8: stray load in the middle of a sweep
        run_case("R8 stray load", from_errs(e8), 100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule